// File: doc/BRIEF.md
# Serial Converter Conversion-and-Read Sequencer

This block sits on the host side of a 12-bit sampling converter that has a serial output port. While its run input is held high, it keeps the converter busy. For each conversion it drives an active-low start strobe and watches the converter's busy line. It then clocks a 16-bit frame out of the converter with its own serial clock and presents the 12-bit result with a one-cycle valid strobe. All timing (strobe width, serial clock half period, settling gaps, busy limit) is counted in system clock cycles and set by parameters.

Two orderings are supported, and one is chosen at the start of every conversion. In the default ordering the frame is read only after busy has fallen, and a settling gap separates the last serial clock edge from the next start strobe. In the overlapped ordering the result of the previous conversion is read while the current one is still running. After busy falls, an acquisition wait follows. The first overlapped conversion after idle, or after a timeout, has no earlier result, so its frame is dropped. Each frame must carry four zero guard bits above the data, and a frame that does not raises an error strobe instead of a sample. If busy fails to fall within a cycle limit, the sequencer flags a timeout and moves on to the next conversion.

Top module: `adcseq_ctrl`

## Requirements
- R1: While reset is asserted, and at the first cycle after it, the start strobe `cnv_n_o` is high, `sclk_o` is low, and `sample_vld_o`, `frame_err_o` and `busy_tmo_o` are low.
- R2: Conversion behaviour is tied to the run input:
  - With `run_en_i` low in idle, no start strobe is issued.
  - With it high, the sequencer drives `cnv_n_o` low for CNV_LOW_CYC cycles, and each falling edge starts one conversion.
  - Conversions repeat back to back while `run_en_i` is high.
  - Once `run_en_i` is low, the sequencer finishes the current conversion cycle and returns to idle.
- R3: In the default ordering (`overlap_i` = 0 when the strobe falls), `sclk_o` never rises between a start strobe falling edge and the falling edge of busy.
- R4: The serial clock follows a fixed read pattern:
  - `sclk_o` rests low.
  - Each read is exactly 16 pulses, and each high and each low phase lasts SCLK_HALF_CYC cycles. The default of 7 cycles gives at least 50 ns per phase at 125 MHz.
  - `sdata_i` is sampled as `sclk_o` falls, most significant bit first. The converter is expected to update `sdata_i` after each rising edge.
- R5: In the default ordering, at least GAP_CYC cycles pass between the last falling edge of `sclk_o` of a read and the next falling edge of `cnv_n_o`.
- R6: In the overlapped ordering (`overlap_i` = 1 when the strobe falls):
  - The read of the previous result begins once `cnv_n_o` returns high.
  - The read completes before the next falling edge of `cnv_n_o`.
  - After busy falls, the sequencer waits ACQ_CYC cycles before the next strobe.
- R7: The first overlapped conversion after idle or after a timeout produces neither `sample_vld_o` nor `frame_err_o`. Each later overlapped conversion delivers the result of the conversion before it.
- R8: When bits 15..12 of the received frame are all zero, `sample_o` takes bits 11..0 and `sample_vld_o` pulses for one cycle.
- R9: When any of bits 15..12 of the frame is one, `frame_err_o` pulses for one cycle and `sample_vld_o` stays low.
- R10: A busy timeout is handled as follows:
  - If busy has not risen and fallen within BUSY_TMO_CYC cycles of `cnv_n_o` returning high, `busy_tmo_o` pulses for one cycle.
  - That conversion produces no read in the default ordering and no sample.
  - The sequencer continues with its gap and the next conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en_i | input | 1 | Keep converting while high |
| overlap_i | input | 1 | 1 selects reading the previous result during conversion; sampled at each strobe |
| busy_i | input | 1 | Converter busy line, asynchronous, synchronised inside |
| sdata_i | input | 1 | Converter serial data |
| cnv_n_o | output | 1 | Active-low conversion start strobe; falling edge starts a conversion |
| sclk_o | output | 1 | Serial read clock, rests low |
| sample_o | output | 12 | Last good 12-bit result |
| sample_vld_o | output | 1 | One-cycle strobe: `sample_o` updated |
| frame_err_o | output | 1 | One-cycle strobe: guard bits of a frame were not zero |
| busy_tmo_o | output | 1 | One-cycle strobe: busy did not finish within the limit |

## Verification
The hardest situation to reach is a busy timeout in the middle of a continuous run. After the timeout, the sequencer must drop exactly that conversion and still line up the following frames with the right results. The behavioural converter partner has a hold flag that keeps busy high past the limit. The stimulus releases the flag once the timeout strobe appears, so the partner returns to waiting for the next strobe during the gap. The overlapped ordering is also awkward, because each frame carries the previous conversion's value. The scoreboard therefore queues results shifted by one conversion and expects nothing for the first overlapped frame, which holds stale data from an earlier run.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_CONV,
        ST_READ,
        ST_GAP
    } seq_state_e;

endpackage

// File: rtl/adcseq_shift_rx.sv
// Serial frame receiver: generates FRAME_BITS clock pulses and shifts data in
// on each falling edge of the generated clock.
module adcseq_shift_rx #(
    parameter int FRAME_BITS = 16,
    parameter int HALF_CYC   = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  sdata_i,
    output logic                  sclk_o,
    output logic                  active_o,
    output logic                  done_o,
    output logic [FRAME_BITS-1:0] word_o
);
    localparam int DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int BW = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        logic                  active;
        logic                  sclk;
        logic [DW-1:0]         div;
        logic [BW-1:0]         nbit;
        logic [FRAME_BITS-1:0] sh;
        logic                  done;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d      = rx_q;
        rx_d.done = 1'b0;
        if (!rx_q.active) begin
            if (start_i) begin
                rx_d.active = 1'b1;
                rx_d.sclk   = 1'b0;
                rx_d.div    = '0;
                rx_d.nbit   = '0;
            end
        end else begin
            if (rx_q.div == DW'(HALF_CYC - 1)) begin
                rx_d.div  = '0;
                rx_d.sclk = !rx_q.sclk;
                if (rx_q.sclk) begin
                    rx_d.sh   = {rx_q.sh[FRAME_BITS-2:0], sdata_i};
                    rx_d.nbit = rx_q.nbit + 1'b1;
                    if (rx_q.nbit == BW'(FRAME_BITS - 1)) begin
                        rx_d.active = 1'b0;
                        rx_d.done   = 1'b1;
                    end
                end
            end else begin
                rx_d.div = rx_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign sclk_o   = rx_q.sclk;
    assign active_o = rx_q.active;
    assign done_o   = rx_q.done;
    assign word_o   = rx_q.sh;

    // R4: a new read is never requested while one is still running
    assert_no_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.active |-> !start_i);

endmodule

// File: rtl/adcseq_frame_chk.sv
// Guard-bit check of a received frame and result register.
module adcseq_frame_chk #(
    parameter int FRAME_BITS = 16,
    parameter int DATA_BITS  = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  done_i,
    input  logic                  keep_i,
    input  logic [FRAME_BITS-1:0] word_i,
    output logic [DATA_BITS-1:0]  sample_o,
    output logic                  valid_o,
    output logic                  err_o
);
    typedef struct packed {
        logic [DATA_BITS-1:0] sample;
        logic                 valid;
        logic                 err;
    } fc_t;

    fc_t fc_d, fc_q;
    logic guard_ok;

    assign guard_ok = (word_i[FRAME_BITS-1:DATA_BITS] == '0);

    always_comb begin
        fc_d       = fc_q;
        fc_d.valid = 1'b0;
        fc_d.err   = 1'b0;
        if (done_i && keep_i) begin
            if (guard_ok) begin
                fc_d.valid  = 1'b1;
                fc_d.sample = word_i[DATA_BITS-1:0];
            end else begin
                fc_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fc_q <= '0;
        end else begin
            fc_q <= fc_d;
        end
    end

    assign sample_o = fc_q.sample;
    assign valid_o  = fc_q.valid;
    assign err_o    = fc_q.err;

    // R8: the valid strobe is a single-cycle pulse
    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R8: the held sample only changes together with a valid strobe
    assert_sample_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |=> (valid_o || $stable(sample_o)));

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl #(
    parameter int CNV_LOW_CYC   = 4,
    parameter int SCLK_HALF_CYC = 7,
    parameter int GAP_CYC       = 50,
    parameter int ACQ_CYC       = 188,
    parameter int BUSY_TMO_CYC  = 1500,
    parameter int SYNC_STAGES   = 2,
    parameter int FRAME_BITS    = 16,
    parameter int DATA_BITS     = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_en_i,
    input  logic                 overlap_i,
    input  logic                 busy_i,
    input  logic                 sdata_i,
    output logic                 cnv_n_o,
    output logic                 sclk_o,
    output logic [DATA_BITS-1:0] sample_o,
    output logic                 sample_vld_o,
    output logic                 frame_err_o,
    output logic                 busy_tmo_o
);
    import adcseq_pkg::*;

    localparam int MAX_A = (GAP_CYC > ACQ_CYC) ? GAP_CYC : ACQ_CYC;
    localparam int MAX_B = (MAX_A > BUSY_TMO_CYC) ? MAX_A : BUSY_TMO_CYC;
    localparam int MAX_C = (MAX_B > CNV_LOW_CYC) ? MAX_B : CNV_LOW_CYC;
    localparam int CW    = $clog2(MAX_C + 1) + 1;
    localparam int PW    = $clog2(FRAME_BITS + 2);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          cnv_n;
        logic          ovl;
        logic          have_prev;
        logic          busy_seen;
        logic          rd_seen;
        logic          keep;
        logic          rd_start;
        logic          tmo;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // ---------------- busy synchroniser ----------------
    logic [SYNC_STAGES-1:0] bsync_q;
    logic                   busy_s;

    generate
        if (SYNC_STAGES > 1) begin : g_sync_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bsync_q <= '0;
                end else begin
                    bsync_q <= {bsync_q[SYNC_STAGES-2:0], busy_i};
                end
            end
        end else begin : g_sync_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bsync_q <= '0;
                end else begin
                    bsync_q <= busy_i;
                end
            end
        end
    endgenerate

    assign busy_s = bsync_q[SYNC_STAGES-1];

    // ---------------- serial receiver ----------------
    logic                  rx_done;
    logic                  rx_active;
    logic [FRAME_BITS-1:0] rx_word;

    adcseq_shift_rx #(
        .FRAME_BITS (FRAME_BITS),
        .HALF_CYC   (SCLK_HALF_CYC)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (ctl_q.rd_start),
        .sdata_i  (sdata_i),
        .sclk_o   (sclk_o),
        .active_o (rx_active),
        .done_o   (rx_done),
        .word_o   (rx_word)
    );

    adcseq_frame_chk #(
        .FRAME_BITS (FRAME_BITS),
        .DATA_BITS  (DATA_BITS)
    ) u_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_i   (rx_done),
        .keep_i   (ctl_q.keep),
        .word_i   (rx_word),
        .sample_o (sample_o),
        .valid_o  (sample_vld_o),
        .err_o    (frame_err_o)
    );

    // ---------------- sequencer ----------------
    logic conv_end;
    logic rd_ok;
    logic [CW-1:0] gap_lim;

    assign conv_end = ctl_q.busy_seen && !busy_s;
    assign rd_ok    = ctl_q.rd_seen || rx_done;
    assign gap_lim  = ctl_q.ovl ? CW'(ACQ_CYC - 1) : CW'(GAP_CYC - 1);

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.rd_start = 1'b0;
        ctl_d.tmo      = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.have_prev = 1'b0;
                ctl_d.cnv_n     = 1'b1;
                if (run_en_i) begin
                    ctl_d.st    = ST_PULSE;
                    ctl_d.cnt   = '0;
                    ctl_d.cnv_n = 1'b0;
                    ctl_d.ovl   = overlap_i;
                end
            end
            ST_PULSE: begin
                if (ctl_q.cnt == CW'(CNV_LOW_CYC - 1)) begin
                    ctl_d.cnv_n     = 1'b1;
                    ctl_d.st        = ST_CONV;
                    ctl_d.cnt       = '0;
                    ctl_d.busy_seen = 1'b0;
                    ctl_d.rd_seen   = !ctl_q.ovl;
                    if (ctl_q.ovl) begin
                        ctl_d.rd_start = 1'b1;
                        ctl_d.keep     = ctl_q.have_prev;
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_CONV: begin
                if (ctl_q.cnt != '1) begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
                ctl_d.busy_seen = ctl_q.busy_seen || busy_s;
                ctl_d.rd_seen   = rd_ok;
                if (conv_end && rd_ok) begin
                    ctl_d.have_prev = 1'b1;
                    if (!ctl_q.ovl) begin
                        ctl_d.st       = ST_READ;
                        ctl_d.rd_start = 1'b1;
                        ctl_d.keep     = 1'b1;
                    end else begin
                        ctl_d.st  = ST_GAP;
                        ctl_d.cnt = '0;
                    end
                end else if ((ctl_q.cnt >= CW'(BUSY_TMO_CYC - 1)) && rd_ok) begin
                    ctl_d.tmo       = 1'b1;
                    ctl_d.have_prev = 1'b0;
                    ctl_d.st        = ST_GAP;
                    ctl_d.cnt       = '0;
                end
            end
            ST_READ: begin
                if (rx_done) begin
                    ctl_d.st  = ST_GAP;
                    ctl_d.cnt = '0;
                end
            end
            ST_GAP: begin
                if (ctl_q.cnt >= gap_lim) begin
                    if (run_en_i) begin
                        ctl_d.st    = ST_PULSE;
                        ctl_d.cnt   = '0;
                        ctl_d.cnv_n = 1'b0;
                        ctl_d.ovl   = overlap_i;
                    end else begin
                        ctl_d.st = ST_IDLE;
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            default: begin
                ctl_d.st    = ST_IDLE;
                ctl_d.cnv_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.st    <= ST_IDLE;
            ctl_q.cnv_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cnv_n_o    = ctl_q.cnv_n;
    assign busy_tmo_o = ctl_q.tmo;

    // ---------------- checker state for assertions ----------------
    logic [PW-1:0] pulses_q;
    logic          sclk_prev_q;
    logic [CW-1:0] since_rd_q;
    logic          last_def_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulses_q    <= '0;
            sclk_prev_q <= 1'b0;
            since_rd_q  <= '0;
            last_def_q  <= 1'b0;
        end else begin
            sclk_prev_q <= sclk_o;
            if (ctl_q.rd_start) begin
                pulses_q <= '0;
            end else if (sclk_o && !sclk_prev_q) begin
                pulses_q <= pulses_q + 1'b1;
            end
            if (rx_done) begin
                since_rd_q <= '0;
                last_def_q <= !ctl_q.ovl;
            end else if (since_rd_q != '1) begin
                since_rd_q <= since_rd_q + 1'b1;
            end
        end
    end

    // R2: the start strobe stays low for more than one cycle
    assert_strobe_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv_n_o) |=> (!cnv_n_o || (CNV_LOW_CYC < 2)));

    // R3: no serial clock while a default-ordering conversion runs
    assert_no_sclk_in_conv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_CONV && !ctl_q.ovl) |-> !sclk_o);

    // R4: a read completes after exactly FRAME_BITS rising edges
    assert_pulse_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> (pulses_q == PW'(FRAME_BITS)));

    // R5: settling gap after a default-ordering read
    assert_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cnv_n_o) && last_def_q) |-> (since_rd_q >= CW'(GAP_CYC)));

    // R6: a read never straddles the start strobe
    assert_no_straddle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv_n_o) |-> !rx_active);

    // R9: a frame yields either a sample or an error, never both
    assert_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_vld_o && frame_err_o));

    // R10: a timeout is never reported while a start strobe is low
    assert_tmo_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_tmo_o |-> cnv_n_o);

endmodule

// File: tb/adcseq_ctrl_tb.sv
`timescale 1ns/1ps
module adcseq_ctrl_tb;

    localparam int HALF    = 7;
    localparam int GAP     = 50;
    localparam int CONV_NS = 8000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run_en;
    logic        ovl;
    logic        busy;
    logic        sdata;
    logic        cnv_n;
    logic        sclk;
    logic [11:0] sample;
    logic        vld;
    logic        ferr;
    logic        tmo;

    always #4 clk = ~clk;

    adcseq_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_en_i     (run_en),
        .overlap_i    (ovl),
        .busy_i       (busy),
        .sdata_i      (sdata),
        .cnv_n_o      (cnv_n),
        .sclk_o       (sclk),
        .sample_o     (sample),
        .sample_vld_o (vld),
        .frame_err_o  (ferr),
        .busy_tmo_o   (tmo)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural converter partner ----------------
    logic [15:0] conv_q[$];
    logic [15:0] out_word = 16'h0;
    int          bidx = 0;
    bit          stuck = 0;

    initial begin
        busy  = 1'b0;
        sdata = 1'b0;
    end

    always begin
        logic [15:0] cur;
        @(negedge cnv_n);
        bidx = 0;
        cur  = (conv_q.size() > 0) ? conv_q.pop_front() : 16'h0;
        #21;
        busy = 1'b1;
        if (stuck) begin
            wait (!stuck);
        end else begin
            #(CONV_NS);
        end
        busy     = 1'b0;
        out_word = cur;
    end

    always @(posedge sclk) begin
        #1;
        sdata = (bidx < 16) ? out_word[15 - bidx] : 1'b0;
        bidx++;
    end

    // ---------------- scoreboard ----------------
    logic [12:0] exp_q[$];
    bit          bench_ovl = 0;
    int          vld_cnt = 0;
    int          tmo_cnt = 0;

    task automatic push_conv(input logic [15:0] w);
        conv_q.push_back(w);
    endtask

    task automatic push_exp(input bit err, input logic [11:0] code);
        exp_q.push_back({err, code});
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (tmo) tmo_cnt++;
            if (vld || ferr) begin
                if (vld) vld_cnt++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7/R8/R9", "unexpected strobe", int'({ferr, sample}), -1);
                end else begin
                    logic [12:0] e;
                    e = exp_q.pop_front();
                    if (e[12]) begin
                        check(ferr && !vld, "R9", "frame error strobe", int'({ferr, vld}), 2);
                    end else begin
                        check(vld && (sample == e[11:0]), "R8", "sample value",
                              int'({ferr, sample}), int'(e[11:0]));
                    end
                end
            end
        end
    end

    // ---------------- timing monitors ----------------
    logic prev_sclk = 1'b0;
    logic prev_cnv  = 1'b1;
    logic prev_busy = 1'b0;
    bit   in_conv   = 0;
    int   falls     = 0;
    int   rise_cnt  = 0;
    int   since_fall = 100000;
    int   run_len   = 0;
    int   min_w     = 1000;
    int   r3_viol   = 0;
    int   r4_bad    = 0;
    int   r5_bad    = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            since_fall++;
            run_len++;
            if (sclk && !prev_sclk) begin
                if (in_conv && !bench_ovl) r3_viol++;
                if (rise_cnt > 0 && run_len < min_w) min_w = run_len;
                rise_cnt++;
                run_len = 0;
            end
            if (!sclk && prev_sclk) begin
                if (run_len < min_w) min_w = run_len;
                since_fall = 0;
                run_len    = 0;
            end
            if (prev_busy && !busy) in_conv = 0;
            if (!cnv_n && prev_cnv) begin
                if (rise_cnt != 0 && rise_cnt != 16) r4_bad++;
                if (!bench_ovl && rise_cnt == 16 && since_fall < GAP) r5_bad++;
                rise_cnt = 0;
                in_conv  = 1;
                falls++;
            end
            prev_sclk = sclk;
            prev_cnv  = cnv_n;
            prev_busy = busy;
        end
    end

    // ---------------- run control ----------------
    task automatic run(input bit ov, input int n);
        int f0;
        ovl       = ov;
        bench_ovl = ov;
        f0        = falls;
        run_en    = 1'b1;
        while (falls < f0 + n) @(negedge clk);
        run_en = 1'b0;
        repeat (3000) @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: actual=%0h expected=%0h", 0, 1);
        summary();
        $finish;
    end

    initial begin
        int f0;
        int v0;
        rst_n  = 1'b0;
        run_en = 1'b0;
        ovl    = 1'b0;
        repeat (10) @(negedge clk);
        // R1: reset state
        check(cnv_n == 1'b1, "R1", "strobe high in reset", int'(cnv_n), 1);
        check(sclk == 1'b0, "R1", "sclk low in reset", int'(sclk), 0);
        check({vld, ferr, tmo} == 3'b000, "R1", "strobes low in reset", int'({vld, ferr, tmo}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cnv_n == 1'b1 && sclk == 1'b0, "R1", "idle after reset", int'({cnv_n, sclk}), 2);
        repeat (20) @(negedge clk);
        check(cnv_n == 1'b1 && falls == 0, "R2", "no strobe without run", falls, 0);

        // default ordering: R2, R3, R4, R5, R8
        push_conv({4'h0, 12'h000}); push_exp(1'b0, 12'h000);
        push_conv({4'h0, 12'hFFF}); push_exp(1'b0, 12'hFFF);
        push_conv({4'h0, 12'hA5C}); push_exp(1'b0, 12'hA5C);
        push_conv({4'h0, 12'h3E1}); push_exp(1'b0, 12'h3E1);
        run(1'b0, 4);
        check(exp_q.size() == 0, "R8", "default samples delivered", exp_q.size(), 0);
        check(falls == 4 && cnv_n == 1'b1, "R2", "stops after run drops", falls, 4);

        // guard bits: R9
        push_conv(16'h8123); push_exp(1'b1, 12'h123);
        push_conv({4'h0, 12'h456}); push_exp(1'b0, 12'h456);
        v0 = vld_cnt;
        run(1'b0, 2);
        check(exp_q.size() == 0, "R9", "error then sample", exp_q.size(), 0);
        check(vld_cnt - v0 == 1, "R9", "no sample for bad frame", vld_cnt - v0, 1);

        // overlapped ordering: R6, R7
        push_conv({4'h0, 12'h111});
        push_conv({4'h0, 12'h7FF}); push_exp(1'b0, 12'h111);
        push_conv({4'h0, 12'h800}); push_exp(1'b0, 12'h7FF);
        push_conv({4'h0, 12'hC3A}); push_exp(1'b0, 12'h800);
        v0 = vld_cnt;
        run(1'b1, 4);
        check(exp_q.size() == 0, "R6", "overlapped samples delivered", exp_q.size(), 0);
        check(vld_cnt - v0 == 3, "R7", "first overlapped frame dropped", vld_cnt - v0, 3);

        // busy timeout during a continuous run: R10
        push_conv({4'h0, 12'h0AA});
        push_conv({4'h0, 12'h5A5}); push_exp(1'b0, 12'h5A5);
        push_conv({4'h0, 12'h0F0}); push_exp(1'b0, 12'h0F0);
        v0        = vld_cnt;
        ovl       = 1'b0;
        bench_ovl = 1'b0;
        stuck     = 1;
        f0        = falls;
        run_en    = 1'b1;
        for (int i = 0; i < 4000 && tmo_cnt == 0; i++) @(negedge clk);
        stuck = 0;
        while (falls < f0 + 3) @(negedge clk);
        run_en = 1'b0;
        repeat (3000) @(negedge clk);
        check(tmo_cnt == 1, "R10", "timeout strobe count", tmo_cnt, 1);
        check(vld_cnt - v0 == 2, "R10", "timed-out conversion skipped", vld_cnt - v0, 2);
        check(exp_q.size() == 0, "R10", "later results aligned", exp_q.size(), 0);

        // timing monitors
        check(r3_viol == 0, "R3", "sclk during default conversion", r3_viol, 0);
        check(r4_bad == 0, "R4", "reads not 16 pulses", r4_bad, 0);
        check(min_w >= HALF, "R4", "min sclk phase width", min_w, HALF);
        check(r5_bad == 0, "R5", "gap before strobe", r5_bad, 0);

        summary();
        $finish;
    end

endmodule